// File: doc/BRIEF.md
# Keyed Configuration Register Unit

This block is the configuration front end of a legacy multi-function I/O controller. A host reaches it through a small 8-bit port window with four byte offsets. Offset 0 takes an unlock key, offset 1 holds the register index and offset 2 reads or writes the register that the index selects. Offset 3 has no function. Data access works only after the host has written the correct key. Any other value written to the key offset locks the unit again.

There are 22 byte-wide configuration registers, and all of them are exported on a flat output bus for downstream decode. The key depends on one register bit, so software can move the unit to a second key. Bit 6 of register 9 can set a protection flag. While that flag is set, registers 0x00 to 0x0B can be neither read nor written. Reset defaults come from fixed constants and two strap inputs.

Top module: `keyed_cfg_regfile`

## Requirements
- R1: After reset the registers hold 0x00=0xD0, 0x01=0x2C, 0x03=0x70, 0x07=0xF5, 0x09=strapReg9, 0x0A=0x1F, 0x0C=0x0C with bit 5 equal to strapKeySel, and 0x0D=0xA3. Every other register is 0. Reset also leaves the unit locked with index 0. Register i appears on regsFlat[8*i+7:8*i].
- R2: A write to offset 0 with a value equal to the current key unlocks the unit. A write to offset 0 with any other value locks it.
- R3: The current key is 0x88 with bit 0 replaced by bit 5 of register 0x0C. The key is therefore 0x88 or 0x89, and it follows that register bit at once.
- R4: A write to offset 1 sets the 5-bit index when the value is 0x15 or less, whether or not the unit is locked. A larger value leaves the index unchanged.
- R5: While the unit is locked, writes to offset 2 change no register.
- R6: While the protection flag is set, writes to offset 2 aimed at indices 0x00 to 0x0B are ignored, and reads of those indices return 0xFF. Indices 0x0C to 0x15 stay fully accessible.
- R7: Bit 2 of register 6 is always stored as 0, whatever value is written.
- R8: Reads are combinational and valid in the cycle of rdEn. While locked, every offset reads 0xFF. While unlocked, offsets 0 and 3 read 0xFF. Writes to offset 3 have no effect.
- R9: While unlocked, a read of offset 1 returns the current index, zero-extended to 8 bits. A read of offset 2 returns the selected register, subject to R6.
- R10: Reset clears the protection flag, even when the strap value puts a 1 in bit 6 of register 9. An accepted write to register 9 that changes bit 6 loads that bit into the flag. A write that leaves bit 6 unchanged leaves the flag as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strapReg9 | input | 8 | Strap value loaded into register 9 at reset |
| strapKeySel | input | 1 | Strap value loaded into bit 5 of register 0x0C at reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| addr | input | 2 | Port offset within the window |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data, combinational |
| regsFlat | output | 176 | All register contents, register i in bits 8*i+7 to 8*i |

## Verification
The key offset is driven with the wrong key, the right key and the other key after bit 5 of register 0x0C is flipped. These cases separate a fixed key from a key that tracks the register, and separate unlock from relock. Index writes use the edge values 0x15 and 0x16 and a value written while locked. These cases separate the range cap from the lock gating. Data accesses on each side of the 0x0B boundary, with the protection flag clear and then set, separate the protected bank from the open bank. A second reset with bit 6 set in the strap value shows that reset clears the flag independently of that strap bit.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;
  localparam int DATA_W   = 8;
  localparam int KEY_REG  = 12;
  localparam int KEY_BIT  = 5;
  localparam int PROT_REG = 9;
  localparam int PROT_BIT = 6;
  localparam int MASK_REG = 6;
  localparam int MASK_BIT = 2;

  localparam int OFS_KEY  = 0;
  localparam int OFS_IDX  = 1;
  localparam int OFS_DATA = 2;

  typedef struct packed {
    logic keyWr;
    logic idxWr;
    logic dataWr;
    logic idxRd;
    logic dataRd;
  } cfgStrb_t;

  function automatic logic [DATA_W-1:0] resetValue(input int idx,
                                                   input logic [DATA_W-1:0] s9,
                                                   input logic kSel);
    logic [DATA_W-1:0] v;
    case (idx)
      0:        v = 8'hD0;
      1:        v = 8'h2C;
      3:        v = 8'h70;
      7:        v = 8'hF5;
      PROT_REG: v = s9;
      10:       v = 8'h1F;
      KEY_REG:  begin v = 8'h0C; v[KEY_BIT] = kSel; end
      13:       v = 8'hA3;
      default:  v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/cfgreg_ctrl.sv
module cfgreg_ctrl
  import cfgreg_pkg::*;
#(
  parameter int NUM_REGS = 22,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] curKey,
  output cfgStrb_t          strb,
  output logic              unlocked,
  output logic [IDX_W-1:0]  index
);
  localparam int MAX_INDEX = NUM_REGS - 1;

  logic idxOk;
  assign idxOk = ({24'd0, wrData} <= 32'(MAX_INDEX));

  always_comb begin
    strb        = '0;
    strb.keyWr  = wrEn && (addr == 2'(OFS_KEY));
    strb.idxWr  = wrEn && (addr == 2'(OFS_IDX)) && idxOk;
    strb.dataWr = wrEn && (addr == 2'(OFS_DATA)) && unlocked;
    strb.idxRd  = rdEn && (addr == 2'(OFS_IDX)) && unlocked;
    strb.dataRd = rdEn && (addr == 2'(OFS_DATA)) && unlocked;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unlocked <= 1'b0;
      index    <= '0;
    end else begin
      if (strb.keyWr) unlocked <= (wrData == curKey);
      if (strb.idxWr) index    <= wrData[IDX_W-1:0];
    end
  end

  // R4: an out-of-range index write leaves the index untouched
  p_idx_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'(OFS_IDX) && !idxOk) |=> $stable(index));

  // R2: writing the current key unlocks
  p_key_unlock_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'(OFS_KEY) && wrData == curKey) |=> unlocked);

  // R2: writing a wrong key locks
  p_key_lock_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'(OFS_KEY) && wrData != curKey) |=> !unlocked);
endmodule

// File: rtl/cfgreg_data.sv
module cfgreg_data
  import cfgreg_pkg::*;
#(
  parameter int NUM_REGS    = 22,
  parameter int PROT_LAST   = 11,
  parameter logic [7:0] KEY_BASE = 8'h88,
  localparam int IDX_W      = $clog2(NUM_REGS),
  localparam int FLAT_W     = NUM_REGS * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] strapReg9,
  input  logic              strapKeySel,
  input  cfgStrb_t          strb,
  input  logic              unlocked,
  input  logic [IDX_W-1:0]  index,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] curKey,
  output logic [DATA_W-1:0] rdData,
  output logic [FLAT_W-1:0] regsFlat
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic              protFlag;
  logic              inProtBank;
  logic              wrAccept;
  logic [DATA_W-1:0] wrVal;

  assign inProtBank = ({27'd0, index} <= 32'(PROT_LAST));
  assign wrAccept   = strb.dataWr && !(protFlag && inProtBank);

  always_comb begin
    wrVal = wrData;
    if ({27'd0, index} == 32'(MASK_REG)) wrVal[MASK_BIT] = 1'b0;
  end

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN)
          regs[i] <= resetValue(i, strapReg9, strapKeySel);
        else if (wrAccept && ({27'd0, index} == 32'(i)))
          regs[i] <= wrVal;
      end
      assign regsFlat[i*DATA_W +: DATA_W] = regs[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)
      protFlag <= 1'b0;
    else if (wrAccept && ({27'd0, index} == 32'(PROT_REG)) &&
             (wrData[PROT_BIT] != regs[PROT_REG][PROT_BIT]))
      protFlag <= wrData[PROT_BIT];
  end

  always_comb begin
    curKey = KEY_BASE;
    curKey[0] = KEY_BASE[0] | regs[KEY_REG][KEY_BIT];
  end

  always_comb begin
    rdData = '1;
    if (strb.idxRd)
      rdData = DATA_W'(index);
    else if (strb.dataRd && !(protFlag && inProtBank))
      rdData = regs[index];
  end

  // R5: locked data writes change nothing
  p_locked_nowr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!unlocked && !strb.dataWr) |=> $stable(regsFlat));

  // R6: protected low-bank writes change nothing
  p_prot_nowr_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && protFlag && inProtBank) |=> $stable(regsFlat));

  // R7: the masked bit of register 6 never stores a one
  p_mask_bit_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWr && {27'd0, index} == 32'(MASK_REG)) |=> (regs[MASK_REG][MASK_BIT] == 1'b0));

  // R8: no read path opens while locked
  p_locked_rd_r8: assert property (@(posedge clk) disable iff (!rstN)
    !unlocked |-> (rdData == '1));
endmodule

// File: rtl/keyed_cfg_regfile.sv
module keyed_cfg_regfile
  import cfgreg_pkg::*;
#(
  parameter int NUM_REGS  = 22,
  parameter int PROT_LAST = 11,
  parameter logic [7:0] KEY_BASE = 8'h88,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int FLAT_W   = NUM_REGS * 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        strapReg9,
  input  logic              strapKeySel,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [1:0]        addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic [FLAT_W-1:0] regsFlat
);
  cfgStrb_t         strb;
  logic             unlocked;
  logic [IDX_W-1:0] index;
  logic [7:0]       curKey;

  cfgreg_ctrl #(.NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .curKey(curKey), .strb(strb),
    .unlocked(unlocked), .index(index)
  );

  cfgreg_data #(.NUM_REGS(NUM_REGS), .PROT_LAST(PROT_LAST), .KEY_BASE(KEY_BASE)) u_data (
    .clk(clk), .rstN(rstN), .strapReg9(strapReg9), .strapKeySel(strapKeySel),
    .strb(strb), .unlocked(unlocked), .index(index), .wrData(wrData),
    .curKey(curKey), .rdData(rdData), .regsFlat(regsFlat)
  );
endmodule

// File: tb/tb_keyed_cfg_regfile.sv
module tb_keyed_cfg_regfile;
  localparam int NR = 22;

  logic clk = 0;
  logic rstN = 0;
  logic [7:0] strapReg9 = 8'h09;
  logic strapKeySel = 1'b1;
  logic wrEn = 0, rdEn = 0;
  logic [1:0] addr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] rdData;
  logic [NR*8-1:0] regsFlat;

  keyed_cfg_regfile dut (
    .clk(clk), .rstN(rstN), .strapReg9(strapReg9), .strapKeySel(strapKeySel),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .regsFlat(regsFlat)
  );

  always #5 clk = ~clk;

  int nTests = 0, nFail = 0;
  bit finished = 0;

  // bench model
  logic [7:0] mReg [NR];
  logic mUnl, mProt;
  logic [4:0] mIdx;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t q[$];

  function automatic logic [7:0] mKey();
    return 8'h88 | {7'd0, mReg[12][5]};
  endfunction

  function automatic logic [7:0] mRead(input logic [1:0] a);
    if (!mUnl) return 8'hFF;
    if (a == 2'd1) return {3'd0, mIdx};
    if (a == 2'd2) return (mProt && mIdx <= 5'd11) ? 8'hFF : mReg[mIdx];
    return 8'hFF;
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic [7:0] s9, input logic ks);
    @(negedge clk);
    strapReg9 = s9; strapKeySel = ks; rstN = 0; wrEn = 0; rdEn = 0;
    @(negedge clk);
    rstN = 1;
    for (int i = 0; i < NR; i++) mReg[i] = 8'h00;
    mReg[0] = 8'hD0; mReg[1] = 8'h2C; mReg[3] = 8'h70; mReg[7] = 8'hF5;
    mReg[9] = s9; mReg[10] = 8'h1F; mReg[12] = {2'b00, ks, 5'b01100}; mReg[13] = 8'hA3;
    mUnl = 0; mProt = 0; mIdx = 0;
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1; rdEn = 0; addr = a; wrData = d;
    case (a)
      2'd0: mUnl = (d == mKey());
      2'd1: if (d <= 8'h15) mIdx = d[4:0];
      2'd2: if (mUnl && !(mProt && mIdx <= 5'd11)) begin
              logic [7:0] v;
              v = d;
              if (mIdx == 5'd6) v[2] = 1'b0;
              if (mIdx == 5'd9 && d[6] != mReg[9][6]) mProt = d[6];
              mReg[mIdx] = v;
            end
      default: ;
    endcase
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic doRead(input logic [1:0] a, input string tag);
    item_t it;
    @(negedge clk);
    it.exp = mRead(a); it.tag = tag;
    q.push_back(it);
    wrEn = 0; rdEn = 1; addr = a;
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic chkFlat(input string tag);
    for (int i = 0; i < NR; i++) chk(regsFlat[i*8 +: 8], mReg[i], tag);
  endtask

  // monitor: sample read data mid-low-phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rdEn) begin
        item_t it;
        if (q.size() == 0) begin
          nTests++; nFail++;
          $display("FAIL monitor: read with empty queue, got %02h expected none", rdData);
        end else begin
          it = q.pop_front();
          chk(rdData, it.exp, it.tag);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    doReset(8'h09, 1'b1);
    @(negedge clk);
    chkFlat("R1 reset defaults");
    doRead(2'd1, "R8 locked index read");
    doRead(2'd2, "R8 locked data read");
    doWrite(2'd0, 8'h88);
    doRead(2'd1, "R3 wrong key 0x88 keeps lock");
    doWrite(2'd0, 8'h89);
    doRead(2'd1, "R2 unlock, R9 index reads 0");
    doRead(2'd2, "R9 read reg0");
    doWrite(2'd1, 8'h16);
    doRead(2'd1, "R4 index 0x16 rejected");
    doWrite(2'd1, 8'h15);
    doRead(2'd1, "R4 index 0x15 accepted");
    doWrite(2'd2, 8'h3C);
    doRead(2'd2, "R9 reg15 readback");
    doWrite(2'd1, 8'h10);
    doWrite(2'd2, 8'h5A);
    doRead(2'd2, "R9 reg10 readback");
    doWrite(2'd1, 8'h06);
    doWrite(2'd2, 8'hFF);
    doRead(2'd2, "R7 reg6 bit2 cleared");
    doRead(2'd0, "R8 key port read unlocked");
    doRead(2'd3, "R8 offset3 read unlocked");
    doWrite(2'd3, 8'h00);
    doRead(2'd2, "R8 offset3 write ignored");
    // move key to 0x88
    doWrite(2'd1, 8'h0C);
    doWrite(2'd2, 8'h0C);
    doWrite(2'd0, 8'h89);
    doRead(2'd1, "R2 old key now relocks");
    doWrite(2'd0, 8'h88);
    doRead(2'd1, "R3 key follows reg0C bit5");
    // locked writes
    doWrite(2'd0, 8'h00);
    doWrite(2'd1, 8'h10);
    doWrite(2'd2, 8'hA5);
    @(negedge clk);
    chkFlat("R5 locked write ignored");
    doWrite(2'd0, 8'h88);
    doRead(2'd1, "R4 index written while locked");
    doRead(2'd2, "R5 reg10 unchanged");
    // protection
    doWrite(2'd1, 8'h09);
    doWrite(2'd2, 8'h49);
    doRead(2'd2, "R6 reg9 protected read");
    doWrite(2'd1, 8'h0B);
    doRead(2'd2, "R6 reg0B protected read");
    doWrite(2'd1, 8'h05);
    doWrite(2'd2, 8'h77);
    @(negedge clk);
    chkFlat("R6 protected write ignored, R10 flag set");
    doWrite(2'd1, 8'h0C);
    doRead(2'd2, "R6 reg0C open when protected");
    doWrite(2'd2, 8'h2C);
    doRead(2'd2, "R6 reg0C writable when protected");
    // reset with strap bit6 set
    doReset(8'h4F, 1'b0);
    @(negedge clk);
    chkFlat("R1 reset with second strap set");
    doWrite(2'd0, 8'h88);
    doWrite(2'd1, 8'h09);
    doRead(2'd2, "R10 reset clears protection");
    doWrite(2'd2, 8'h4E);
    doRead(2'd2, "R10 same bit6 leaves flag clear");
    doWrite(2'd2, 8'h0E);
    doRead(2'd2, "R10 bit6 cleared");
    doWrite(2'd2, 8'h4E);
    doRead(2'd2, "R10 bit6 rise sets flag");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule